// File: doc/BRIEF.md
# Cascadable Configuration Bitstream Streamer

This block is the read-out side of a memory that holds an FPGA configuration image. A counter walks through the stored image and puts it on the data output: one bit per clock edge in serial mode, or one whole byte per clock edge in parallel mode. Serial mode sends each byte most significant bit first. The image length and the mode are fixed by parameters. The stored image sits in an internal array. A simple write port fills this array before streaming begins.

A clock edge counts only while the chip enable is high and the output-enable/reset input is low. Holding the output-enable/reset input high returns the counter to the start of the image, so every new configuration begins at address zero. When the counter has moved past the last stored unit, it stays there and the data output goes idle. A cascade-enable output then goes high, and it can drive the chip enable of the next streamer in a chain. The data output has a valid flag and no tri-state driver. While the flag is low, the data output is forced to zero.

Top module: `cfg_stream_top`

## Requirements
- R1: After a synchronous reset (rst_n low on a clock edge), the counter is at unit zero and cascade_en is low. When chip_en is high with oe_reset low, the output presents the first unit of the image. In serial mode that is bit 7 of byte 0; in parallel mode it is byte 0 on bits 7..0.
- R2: In serial mode (dout is 1 bit wide), each counted edge advances one bit. Byte k is sent bit 7 first and bit 0 last, and then byte k+1 follows.
- R3: In parallel mode (dout is 8 bits wide), each counted edge advances one byte. Byte k appears on dout with its bit 0 on dout[0].
- R4: While chip_en is low, clock edges do not move the counter and dout_vld is low. When chip_en returns high, streaming resumes at the unit that was pending.
- R5: While oe_reset is high, dout_vld is low and each clock edge clears the counter. After oe_reset is released, the stream starts again at unit zero.
- R6: Once every unit of the image has been counted, cascade_en is high whenever chip_en is high and oe_reset is low, and dout_vld is low.
- R7: At the end of the image the counter saturates. More counted edges leave cascade_en high, and the stream does not wrap to unit zero until oe_reset or rst_n clears it.
- R8: When cascade_en of one streamer drives chip_en of a second, the second streamer outputs its own image from unit zero, starting in the cycle after the first streamer's last unit.
- R9: Whenever dout_vld is low, dout is all zeros.
- R10: A write with ld_en high stores ld_data at byte address ld_addr. Such a write does not move the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Image write strobe |
| ld_addr | input | AW | Image byte address for a write |
| ld_data | input | 8 | Image byte to write |
| chip_en | input | 1 | Active-high chip enable |
| oe_reset | input | 1 | High: hold counter at zero and idle the output |
| dout | output | DATA_W (1 serial, 8 parallel) | Stream data, zero while not valid |
| dout_vld | output | 1 | Stream data is valid |
| cascade_en | output | 1 | Image exhausted; enables the next device |

## Verification
The assertions check, on every cycle, the rules that govern the counter. A counted edge advances the counter by exactly one. With chip_en low the counter holds its value. oe_reset clears the counter. Once the counter has reached the end of the image it stays there. The assertions also check that dout is zero whenever it is not valid and that cascade_en never coincides with valid data. Only the bench scenarios can show that the bit order and byte order match the loaded image, that streaming resumes at the correct unit after a pause or a clear, and that a chained second device takes over exactly one cycle after the first device's last unit.

// File: rtl/cfg_stream_pkg.sv
// Package: shared mode type and size helpers for the configuration streamer.
// Assumes images are whole bytes; serial mode emits 8 units per byte.
package cfg_stream_pkg;

    typedef enum logic {
        MODE_SERIAL   = 1'b0,
        MODE_PARALLEL = 1'b1
    } stream_mode_e;

    // Number of output units contained in an image of the given byte length.
    function automatic int unsigned units_of(input int unsigned bytes, input stream_mode_e mode);
        return (mode == MODE_PARALLEL) ? bytes : bytes * 8;
    endfunction

    // Width of one output unit for a mode.
    function automatic int unsigned unit_width(input stream_mode_e mode);
        return (mode == MODE_PARALLEL) ? 8 : 1;
    endfunction

endpackage

// File: rtl/cfg_image_mem.sv
// Module: byte array holding the configuration image.
// Write port is synchronous; read port is combinational and returns zero for
// any index at or beyond DEPTH, so the end-of-image index is harmless.
module cfg_image_mem #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned AW    = 4,
    parameter int unsigned RW    = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [RW-1:0] rd_idx,
    output logic [7:0]    rd_byte
);

    logic [7:0] store [DEPTH];

    // Capture one image byte per write strobe.
    always_ff @(posedge clk) begin
        if (wr_en && (32'(wr_addr) < DEPTH)) begin
            store[wr_addr] <= wr_data;
        end
    end

    // Present the byte at the read index, zero past the end.
    always_comb begin
        rd_byte = '0;
        for (int unsigned i = 0; i < DEPTH; i++) begin
            if (32'(rd_idx) == i) begin
                rd_byte = store[i];
            end
        end
    end

endmodule

// File: rtl/cfg_addr_ctr.sv
// Module: saturating address counter of the streamer.
// Advances once per edge while enabled and not cleared, stops at END_UNIT
// (one past the last unit) and returns to zero only on clear or reset.
module cfg_addr_ctr #(
    parameter int unsigned END_UNIT = 128,
    parameter int unsigned CW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          clr,
    output logic [CW-1:0] cnt,
    output logic          at_end
);

    localparam logic [CW-1:0] END_VAL = CW'(END_UNIT);

    logic step;

    // A counted edge: enabled, not cleared, image not yet exhausted.
    always_comb begin
        at_end = (cnt == END_VAL);
        step   = en && !clr && !at_end;
    end

    // Counter update with synchronous reset and clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && (cnt != END_VAL)) |=> (cnt == $past(cnt) + 1'b1));

    assert_hold_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(cnt));

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    assert_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt == END_VAL) && !clr) |=> (cnt == END_VAL));

endmodule

// File: rtl/cfg_unit_sel.sv
// Module: maps the counter to an image byte index and extracts the output
// unit. Serial variant picks one bit, MSB first; parallel passes the byte.
module cfg_unit_sel
    import cfg_stream_pkg::*;
#(
    parameter stream_mode_e MODE = MODE_SERIAL,
    parameter int unsigned  CW   = 8,
    parameter int unsigned  DW   = 1
) (
    input  logic [CW-1:0] cnt,
    input  logic [7:0]    cur_byte,
    output logic [CW-1:0] byte_idx,
    output logic [DW-1:0] unit
);

    generate
        if (MODE == MODE_PARALLEL) begin : g_par
            // Whole byte per unit.
            always_comb begin
                byte_idx = cnt;
                unit     = DW'(cur_byte);
            end
        end else begin : g_ser
            logic [2:0] bit_pos;
            // Byte index from upper counter bits, bit 7 sent first.
            always_comb begin
                byte_idx = cnt >> 3;
                bit_pos  = 3'd7 - cnt[2:0];
                unit     = DW'(cur_byte[bit_pos]);
            end
        end
    endgenerate

endmodule

// File: rtl/cfg_stream_top.sv
// Module: cascadable configuration bitstream streamer.
// Assumes the image is loaded through the write port before streaming; the
// output carries a valid flag instead of a tri-state driver.
module cfg_stream_top
    import cfg_stream_pkg::*;
#(
    parameter int unsigned  IMAGE_BYTES = 16,
    parameter stream_mode_e MODE        = MODE_SERIAL,
    localparam int unsigned AW          = (IMAGE_BYTES > 1) ? $clog2(IMAGE_BYTES) : 1,
    localparam int unsigned DATA_W      = unit_width(MODE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [AW-1:0]     ld_addr,
    input  logic [7:0]        ld_data,
    input  logic              chip_en,
    input  logic              oe_reset,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld,
    output logic              cascade_en
);

    localparam int unsigned UNITS = units_of(IMAGE_BYTES, MODE);
    localparam int unsigned CW    = $clog2(UNITS + 1);

    logic [CW-1:0] cnt;
    logic          at_end;
    logic [CW-1:0] byte_idx;
    logic [7:0]    cur_byte;
    logic [DATA_W-1:0] unit;

    cfg_addr_ctr #(.END_UNIT(UNITS), .CW(CW)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (chip_en),
        .clr    (oe_reset),
        .cnt    (cnt),
        .at_end (at_end)
    );

    cfg_image_mem #(.DEPTH(IMAGE_BYTES), .AW(AW), .RW(CW)) u_mem (
        .clk     (clk),
        .wr_en   (ld_en),
        .wr_addr (ld_addr),
        .wr_data (ld_data),
        .rd_idx  (byte_idx),
        .rd_byte (cur_byte)
    );

    cfg_unit_sel #(.MODE(MODE), .CW(CW), .DW(DATA_W)) u_sel (
        .cnt      (cnt),
        .cur_byte (cur_byte),
        .byte_idx (byte_idx),
        .unit     (unit)
    );

    // Output qualification: valid data, idle zero, and cascade hand-off.
    always_comb begin
        dout_vld   = chip_en && !oe_reset && !at_end;
        dout       = dout_vld ? unit : '0;
        cascade_en = chip_en && !oe_reset && at_end;
    end

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_vld |-> (dout == '0));

    assert_cascade_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cascade_en |-> !dout_vld);

    assert_cascade_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade_en && chip_en && !oe_reset) |=> (chip_en && !oe_reset) |-> cascade_en);

endmodule

// File: tb/cfg_stream_top_tb.sv
// Bench: directed scenarios on a serial streamer chained to a second serial
// streamer, plus a separate parallel streamer.
module cfg_stream_top_tb;
    import cfg_stream_pkg::*;

    localparam int unsigned NB  = 4;
    localparam int unsigned AW  = 2;
    localparam time         CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n;
    logic ld_en_s, ld_en_n, ld_en_p;
    logic [AW-1:0] ld_addr;
    logic [7:0] ld_data;
    logic ce_s, ce_p, oe_reset;
    logic dout_s, vld_s, cas_s;
    logic dout_n, vld_n, cas_n;
    logic [7:0] dout_p;
    logic vld_p, cas_p;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_stream_top #(.IMAGE_BYTES(NB), .MODE(MODE_SERIAL)) u_dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en_s), .ld_addr(ld_addr), .ld_data(ld_data),
        .chip_en(ce_s), .oe_reset(oe_reset), .dout(dout_s), .dout_vld(vld_s), .cascade_en(cas_s));

    cfg_stream_top #(.IMAGE_BYTES(NB), .MODE(MODE_SERIAL)) u_nxt (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en_n), .ld_addr(ld_addr), .ld_data(ld_data),
        .chip_en(cas_s), .oe_reset(oe_reset), .dout(dout_n), .dout_vld(vld_n), .cascade_en(cas_n));

    cfg_stream_top #(.IMAGE_BYTES(NB), .MODE(MODE_PARALLEL)) u_par (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en_p), .ld_addr(ld_addr), .ld_data(ld_data),
        .chip_en(ce_p), .oe_reset(oe_reset), .dout(dout_p), .dout_vld(vld_p), .cascade_en(cas_p));

    function automatic logic [7:0] img(input int seed, input int i);
        return 8'((i * 37 + seed) ^ 8'hA5);
    endfunction

    function automatic logic ser_bit(input int seed, input int u);
        logic [7:0] b;
        b = img(seed, u / 8);
        return b[7 - (u % 8)];
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Advance to the next falling edge and let outputs settle.
    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // R10: load all three images through the write ports.
    task automatic t_load();
        for (int i = 0; i < int'(NB); i++) begin
            @(negedge clk);
            ld_addr = AW'(i);
            ld_data = img(1, i); ld_en_s = 1'b1;
            @(negedge clk);
            ld_en_s = 1'b0; ld_data = img(2, i); ld_en_n = 1'b1;
            @(negedge clk);
            ld_en_n = 1'b0; ld_data = img(3, i); ld_en_p = 1'b1;
            @(negedge clk);
            ld_en_p = 1'b0;
        end
    endtask

    // R1: reset state and first unit.
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0; ce_s = 1'b0; ce_p = 1'b0; oe_reset = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        check("R1 cascade low", {7'b0, cas_s}, 8'h00);
        check("R9 idle zero", {7'b0, dout_s}, 8'h00);
        ce_s = 1'b1; ce_p = 1'b1;
        #1;
        check("R1 serial first", {6'b0, vld_s, dout_s}, {6'b0, 1'b1, ser_bit(1, 0)});
        check("R1 parallel first", dout_p, img(3, 0));
        ce_p = 1'b0;
    endtask

    // R2: serial bits, MSB first, across a byte boundary.
    task automatic t_serial();
        for (int u = 0; u < 12; u++) begin
            check($sformatf("R2 bit %0d", u), {6'b0, vld_s, dout_s}, {6'b0, 1'b1, ser_bit(1, u)});
            tick();
        end
    endtask

    // R4 and R10: pause, load during pause, resume at pending unit.
    task automatic t_hold();
        ce_s = 1'b0;
        ld_addr = AW'(3); ld_data = img(1, 3); ld_en_s = 1'b1;
        tick();
        ld_en_s = 1'b0;
        tick(); tick();
        check("R4 valid low", {7'b0, vld_s}, 8'h00);
        check("R9 dout zero", {7'b0, dout_s}, 8'h00);
        ce_s = 1'b1;
        #1;
        check("R4 R10 resume", {6'b0, vld_s, dout_s}, {6'b0, 1'b1, ser_bit(1, 12)});
        tick();
        check("R4 next", {7'b0, dout_s}, {7'b0, ser_bit(1, 13)});
    endtask

    // R5: clear mid-stream restarts at unit zero.
    task automatic t_oerst();
        oe_reset = 1'b1;
        #1;
        check("R5 valid low", {7'b0, vld_s}, 8'h00);
        tick();
        oe_reset = 1'b0;
        #1;
        check("R5 restart", {6'b0, vld_s, dout_s}, {6'b0, 1'b1, ser_bit(1, 0)});
    endtask

    // R2 R6 R7 R8: drain first device, hand off to second, saturate both.
    task automatic t_drain();
        for (int u = 0; u < int'(NB) * 8; u++) begin
            check($sformatf("R2 drain %0d", u), {6'b0, vld_s, dout_s}, {6'b0, 1'b1, ser_bit(1, u)});
            check("R8 next idle", {6'b0, vld_n, cas_s}, 8'h00);
            tick();
        end
        check("R6 cascade", {6'b0, cas_s, vld_s}, 8'h02);
        for (int u = 0; u < int'(NB) * 8; u++) begin
            check($sformatf("R8 next %0d", u), {6'b0, vld_n, dout_n}, {6'b0, 1'b1, ser_bit(2, u)});
            check("R7 first stays", {7'b0, cas_s}, 8'h01);
            tick();
        end
        check("R6 next cascade", {6'b0, cas_n, vld_n}, 8'h02);
        tick(); tick();
        check("R7 no wrap", {5'b0, cas_s, cas_n, vld_s}, 8'h06);
        oe_reset = 1'b1;
        tick();
        oe_reset = 1'b0;
        #1;
        check("R5 chain clear", {5'b0, cas_s, vld_s, dout_s}, {5'b0, 2'b01, ser_bit(1, 0)});
        ce_s = 1'b0;
    endtask

    // R3 R6 R7: parallel bytes then saturation.
    task automatic t_par();
        oe_reset = 1'b1;
        tick();
        oe_reset = 1'b0; ce_p = 1'b1;
        #1;
        for (int i = 0; i < int'(NB); i++) begin
            check($sformatf("R3 byte %0d", i), dout_p, img(3, i));
            check("R3 valid", {7'b0, vld_p}, 8'h01);
            tick();
        end
        check("R6 par cascade", {6'b0, cas_p, vld_p}, 8'h02);
        tick(); tick();
        check("R7 par no wrap", {6'b0, cas_p, vld_p}, 8'h02);
        check("R9 par zero", dout_p, 8'h00);
    endtask

    initial begin
        rst_n = 1'b0; ld_en_s = 1'b0; ld_en_n = 1'b0; ld_en_p = 1'b0;
        ld_addr = '0; ld_data = '0; ce_s = 1'b0; ce_p = 1'b0; oe_reset = 1'b0;
        t_load();
        t_reset();
        t_serial();
        t_hold();
        t_oerst();
        t_drain();
        t_par();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule